// File: doc/BRIEF.md
# Three-Port Switch Egress Selector

This block decides where a transaction-layer packet entering a three-port switch must go. The switch has one upstream port and two downstream ports, and each downstream port sits behind a virtual bridge. Each bridge holds a memory address window, an IO address window and a bus-number range. A parsed header arrives with its packet class, its ingress port, its target address and its requester ID. The block returns a one-hot egress port or a drop indication.

Memory and IO requests are steered by address. Each one is compared with the window of the matching kind on every downstream bridge. Completions are steered by the bus-number field of the requester ID, which is compared with each bridge's range. A packet that matches nothing heads upstream. The block drops a packet whose chosen target is the port it arrived on. It also raises an unsupported-request flag when a request from the upstream side finds no downstream owner.

The bridge windows are loaded through a small register write port. The header enters through a valid/ready handshake. The decision is registered and holds until the egress side takes it.

Top module: `tlp_route_dec`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every window and bus range is empty, so every packet misses.
- R2: A memory request (in_class 0) goes to the downstream port whose memory window satisfies base <= in_addr <= limit. Both bounds are inclusive. out_egress bit 1 means downstream port 0, bit 2 means downstream port 1, and bit 0 means upstream.
- R3: An IO request (in_class 1) is steered only by the IO windows. The memory windows have no effect on it.
- R4: A completion (in_class 2) goes to the downstream port whose range satisfies sec <= in_rid[15:8] <= sub.
- R5: A completion that arrives on a downstream port (in_port 1 or 2) and matches no downstream range goes upstream (out_egress 3'b001).
- R6: A request, or a packet of any other class (in_class 3), that arrives on the upstream port (in_port 0) and matches no downstream window is dropped. out_drop and out_ur are both 1, and out_egress is 0.
- R7: A request, or a class-3 packet, that arrives on a downstream port and matches no window goes upstream.
- R8: A packet whose selected target equals its own ingress port is dropped with out_ur at 0. This includes a completion from upstream that matches no range.
- R9: A window whose base is greater than its limit never matches. A window whose base equals its limit matches exactly one value.
- R10: When both downstream windows match, downstream port 0 wins.
- R11: The decision appears on out_valid one cycle after in_valid and in_ready are both high. It stays unchanged while out_ready is low. in_ready equals !out_valid || out_ready.
- R12: A write with cfg_we high loads cfg_wdata into the field cfg_field of downstream port cfg_port. The field codes are 0 memory base, 1 memory limit, 2 IO base, 3 IO limit, 4 bus sec and 5 bus sub. The bus fields take cfg_wdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_port | input | 1 | Downstream port being written |
| cfg_field | input | 3 | Field code (see R12) |
| cfg_wdata | input | 32 | Write value |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header accepted this cycle when high with in_valid |
| in_class | input | 2 | 0 memory, 1 IO, 2 completion, 3 other |
| in_port | input | 2 | Ingress: 0 upstream, 1 downstream 0, 2 downstream 1 |
| in_addr | input | 32 | Request address |
| in_rid | input | 16 | Requester ID; bus number in [15:8] |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Egress side takes the decision |
| out_egress | output | 3 | One-hot egress port, 0 when dropped |
| out_drop | output | 1 | Packet is discarded |
| out_ur | output | 1 | Unsupported request |

## Verification
The hardest case to reach is a decision that must hold while the egress side stalls, with a second header already waiting at the input. The stimulus holds out_ready low across several cycles with a new header presented. It then checks that the first decision stays unchanged and the second header is not taken. It then releases out_ready, so that the hand-off and the next acceptance fall on the same edge. Overlapping windows and single-address windows are reached by reprogramming the bridges in the middle of the run.

// File: rtl/tlp_route_pkg.sv
package tlp_route_pkg;
  typedef enum logic [1:0] {
    CLS_MEM   = 2'd0,
    CLS_IO    = 2'd1,
    CLS_CPL   = 2'd2,
    CLS_OTHER = 2'd3
  } pkt_class_e;

  typedef enum logic [2:0] {
    FLD_MEM_BASE = 3'd0,
    FLD_MEM_LIM  = 3'd1,
    FLD_IO_BASE  = 3'd2,
    FLD_IO_LIM   = 3'd3,
    FLD_BUS_SEC  = 3'd4,
    FLD_BUS_SUB  = 3'd5
  } cfg_field_e;
endpackage

// File: rtl/route_window.sv
module route_window #(
  parameter int W = 32
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] val,
  output logic         hit
);
  // inclusive range; lo > hi leaves no value that satisfies both compares
  always_comb hit = (val >= lo) && (val <= hi);
endmodule

// File: rtl/route_cfg_regs.sv
module route_cfg_regs #(
  parameter int NUM_DN = 2,
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  localparam int SEL_W = (NUM_DN > 1) ? $clog2(NUM_DN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEL_W-1:0]              sel,
  input  logic [2:0]                    field,
  input  logic [ADDR_W-1:0]             wdata,
  output logic [NUM_DN-1:0][ADDR_W-1:0] mem_lo,
  output logic [NUM_DN-1:0][ADDR_W-1:0] mem_hi,
  output logic [NUM_DN-1:0][ADDR_W-1:0] io_lo,
  output logic [NUM_DN-1:0][ADDR_W-1:0] io_hi,
  output logic [NUM_DN-1:0][BUS_W-1:0]  bus_lo,
  output logic [NUM_DN-1:0][BUS_W-1:0]  bus_hi
);
  import tlp_route_pkg::*;

  for (genvar p = 0; p < NUM_DN; p++) begin : g_port
    logic en;
    always_comb en = we && (sel == SEL_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_lo[p] <= '1;
        mem_hi[p] <= '0;
        io_lo[p]  <= '1;
        io_hi[p]  <= '0;
        bus_lo[p] <= '1;
        bus_hi[p] <= '0;
      end else if (en) begin
        case (cfg_field_e'(field))
          FLD_MEM_BASE: mem_lo[p] <= wdata;
          FLD_MEM_LIM:  mem_hi[p] <= wdata;
          FLD_IO_BASE:  io_lo[p]  <= wdata;
          FLD_IO_LIM:   io_hi[p]  <= wdata;
          FLD_BUS_SEC:  bus_lo[p] <= wdata[BUS_W-1:0];
          FLD_BUS_SUB:  bus_hi[p] <= wdata[BUS_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/route_select.sv
module route_select #(
  parameter int NUM_DN = 2,
  localparam int NUM_PORTS = NUM_DN + 1,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic [1:0]           cls,
  input  logic [PW-1:0]        ingress,
  input  logic [NUM_DN-1:0]    mem_hit,
  input  logic [NUM_DN-1:0]    io_hit,
  input  logic [NUM_DN-1:0]    bus_hit,
  output logic [NUM_PORTS-1:0] egress,
  output logic                 drop,
  output logic                 ur
);
  import tlp_route_pkg::*;

  logic [NUM_DN-1:0]    hits;
  logic [NUM_PORTS-1:0] target;
  logic [NUM_PORTS-1:0] ing_oh;
  logic                 miss;
  logic                 is_req;

  always_comb begin
    case (pkt_class_e'(cls))
      CLS_MEM: hits = mem_hit;
      CLS_IO:  hits = io_hit;
      CLS_CPL: hits = bus_hit;
      default: hits = '0;
    endcase
    is_req = (pkt_class_e'(cls) != CLS_CPL);

    // lowest-numbered downstream hit wins; default is upstream
    target = NUM_PORTS'(1);
    miss   = 1'b1;
    for (int k = NUM_DN - 1; k >= 0; k--) begin
      if (hits[k]) begin
        target = NUM_PORTS'(1) << (k + 1);
        miss   = 1'b0;
      end
    end

    ing_oh = NUM_PORTS'(1) << ingress;
    if ((target & ing_oh) != '0) begin
      egress = '0;
      drop   = 1'b1;
      ur     = miss && is_req;
    end else begin
      egress = target;
      drop   = 1'b0;
      ur     = 1'b0;
    end
  end
endmodule

// File: rtl/tlp_route_dec.sv
module tlp_route_dec #(
  parameter int NUM_DN = 2,
  parameter int ADDR_W = 32,
  parameter int RID_W  = 16,
  parameter int BUS_W  = 8,
  localparam int NUM_PORTS = NUM_DN + 1,
  localparam int PW = $clog2(NUM_PORTS),
  localparam int SEL_W = (NUM_DN > 1) ? $clog2(NUM_DN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_port,
  input  logic [2:0]           cfg_field,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_class,
  input  logic [PW-1:0]        in_port,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [RID_W-1:0]     in_rid,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] out_egress,
  output logic                 out_drop,
  output logic                 out_ur
);
  logic [NUM_DN-1:0][ADDR_W-1:0] mem_lo, mem_hi, io_lo, io_hi;
  logic [NUM_DN-1:0][BUS_W-1:0]  bus_lo, bus_hi;
  logic [NUM_DN-1:0]             mem_hit, io_hit, bus_hit;
  logic [BUS_W-1:0]              bus_num;
  logic [RID_W-BUS_W-1:0]        unused_rid_lo;

  route_cfg_regs #(.NUM_DN(NUM_DN), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_port), .field(cfg_field),
    .wdata(cfg_wdata), .mem_lo(mem_lo), .mem_hi(mem_hi), .io_lo(io_lo),
    .io_hi(io_hi), .bus_lo(bus_lo), .bus_hi(bus_hi)
  );

  always_comb begin
    bus_num       = in_rid[RID_W-1 -: BUS_W];
    unused_rid_lo = in_rid[RID_W-BUS_W-1:0];
  end

  for (genvar p = 0; p < NUM_DN; p++) begin : g_win
    route_window #(.W(ADDR_W)) u_mem (
      .lo(mem_lo[p]), .hi(mem_hi[p]), .val(in_addr), .hit(mem_hit[p]));
    route_window #(.W(ADDR_W)) u_io (
      .lo(io_lo[p]), .hi(io_hi[p]), .val(in_addr), .hit(io_hit[p]));
    route_window #(.W(BUS_W)) u_bus (
      .lo(bus_lo[p]), .hi(bus_hi[p]), .val(bus_num), .hit(bus_hit[p]));
  end

  logic [NUM_PORTS-1:0] sel_egress;
  logic                 sel_drop, sel_ur;

  route_select #(.NUM_DN(NUM_DN)) u_sel (
    .cls(in_class), .ingress(in_port), .mem_hit(mem_hit), .io_hit(io_hit),
    .bus_hit(bus_hit), .egress(sel_egress), .drop(sel_drop), .ur(sel_ur)
  );

  // decision register
  logic                 vld_q, vld_d;
  logic [NUM_PORTS-1:0] eg_q, eg_d;
  logic                 drop_q, drop_d, ur_q, ur_d;
  logic [PW-1:0]        ing_q, ing_d;
  logic                 accept;

  always_comb begin
    in_ready = !vld_q || out_ready;
    accept   = in_valid && in_ready;
    vld_d    = vld_q;
    eg_d     = eg_q;
    drop_d   = drop_q;
    ur_d     = ur_q;
    ing_d    = ing_q;
    if (accept) begin
      vld_d  = 1'b1;
      eg_d   = sel_egress;
      drop_d = sel_drop;
      ur_d   = sel_ur;
      ing_d  = in_port;
    end else if (out_ready) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      eg_q   <= '0;
      drop_q <= 1'b0;
      ur_q   <= 1'b0;
      ing_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      eg_q   <= eg_d;
      drop_q <= drop_d;
      ur_q   <= ur_d;
      ing_q  <= ing_d;
    end
  end

  always_comb begin
    out_valid  = vld_q;
    out_egress = eg_q;
    out_drop   = drop_q;
    out_ur     = ur_q;
  end

  // R11: accepted header yields a decision on the next cycle
  a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R11: stalled decision is held
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_egress)
                                && $stable(out_drop) && $stable(out_ur));
  // R2: at most one egress port, none exactly when dropped
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_egress) && (out_drop == (out_egress == '0)));
  // R6: unsupported flag only on a drop
  a_r6_ur_drop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ur |-> out_drop);
  // R8: never sent back to its ingress port
  a_r8_no_reflect: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_egress[ing_q]);
endmodule

// File: tb/tlp_route_dec_test.sv
module tlp_route_dec_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_port = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = '0;
  logic [1:0]  in_port = '0;
  logic [31:0] in_addr = '0;
  logic [15:0] in_rid = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_egress;
  logic        out_drop, out_ur;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlp_route_dec uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_class(in_class), .in_port(in_port),
    .in_addr(in_addr), .in_rid(in_rid), .out_valid(out_valid),
    .out_ready(out_ready), .out_egress(out_egress), .out_drop(out_drop),
    .out_ur(out_ur)
  );

  // {class, ingress, addr, rid, egress, drop, ur}
  localparam logic [56:0] VEC [NV] = '{
    {2'd0, 2'd0, 32'h1000_0000, 16'h0000, 3'b010, 1'b0, 1'b0}, // R2 low bound
    {2'd0, 2'd0, 32'h1FFF_FFFF, 16'h0000, 3'b010, 1'b0, 1'b0}, // R2 high bound
    {2'd0, 2'd0, 32'h2000_0000, 16'h0000, 3'b100, 1'b0, 1'b0}, // R2 port 1
    {2'd0, 2'd0, 32'h0FFF_FFFF, 16'h0000, 3'b000, 1'b1, 1'b1}, // R6 below
    {2'd0, 2'd0, 32'h3000_0000, 16'h0000, 3'b000, 1'b1, 1'b1}, // R6 above
    {2'd0, 2'd1, 32'h3000_0000, 16'h0000, 3'b001, 1'b0, 1'b0}, // R7
    {2'd0, 2'd1, 32'h1800_0000, 16'h0000, 3'b000, 1'b1, 1'b0}, // R8
    {2'd0, 2'd2, 32'h1800_0000, 16'h0000, 3'b010, 1'b0, 1'b0}, // R2 peer
    {2'd1, 2'd0, 32'h0000_1800, 16'h0000, 3'b010, 1'b0, 1'b0}, // R3
    {2'd1, 2'd0, 32'h1000_0000, 16'h0000, 3'b000, 1'b1, 1'b1}, // R3 mem ignored
    {2'd1, 2'd0, 32'h0000_2FFF, 16'h0000, 3'b100, 1'b0, 1'b0}, // R3 port 1
    {2'd1, 2'd2, 32'h0000_0800, 16'h0000, 3'b001, 1'b0, 1'b0}, // R7 io
    {2'd2, 2'd0, 32'h0000_0000, 16'h0300, 3'b010, 1'b0, 1'b0}, // R4
    {2'd2, 2'd0, 32'h0000_0000, 16'h09FF, 3'b100, 1'b0, 1'b0}, // R4 sub bound
    {2'd2, 2'd0, 32'h0000_0000, 16'h0200, 3'b010, 1'b0, 1'b0}, // R4 sec bound
    {2'd2, 2'd1, 32'h0000_0000, 16'h0100, 3'b001, 1'b0, 1'b0}, // R5
    {2'd2, 2'd2, 32'h0000_0000, 16'h0A00, 3'b001, 1'b0, 1'b0}, // R5
    {2'd2, 2'd0, 32'h0000_0000, 16'h0A00, 3'b000, 1'b1, 1'b0}, // R8 cpl miss
    {2'd3, 2'd1, 32'h1800_0000, 16'h0000, 3'b001, 1'b0, 1'b0}, // R7 other
    {2'd3, 2'd0, 32'h1800_0000, 16'h0000, 3'b000, 1'b1, 1'b1}  // R6 other
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(logic p, logic [2:0] f, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = p; cfg_field = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one header; sample at the falling edge after the accepting edge
  task automatic send(logic [1:0] c, logic [1:0] ing, logic [31:0] a,
                      logic [15:0] r, output logic [5:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_port = ing; in_addr = a; in_rid = r;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    res = {out_valid, out_egress, out_drop, out_ur};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [5:0] r;
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state
    check("R1 idle", {out_valid, in_ready, 4'b0}, {1'b0, 1'b1, 4'b0});
    @(negedge clk);
    rst_n = 1'b1;
    // R1: empty windows after reset
    send(2'd0, 2'd1, 32'h0000_0000, 16'h0000, r);
    check("R1 empty windows", r, 6'b1_001_00);
    send(2'd2, 2'd2, 32'h0, 16'hFF00, r);
    check("R1 empty bus range", r, 6'b1_001_00);

    // R12: program both bridges
    cfg_wr(1'b0, 3'd0, 32'h1000_0000); cfg_wr(1'b0, 3'd1, 32'h1FFF_FFFF);
    cfg_wr(1'b0, 3'd2, 32'h0000_1000); cfg_wr(1'b0, 3'd3, 32'h0000_1FFF);
    cfg_wr(1'b0, 3'd4, 32'h0000_0002); cfg_wr(1'b0, 3'd5, 32'h0000_0004);
    cfg_wr(1'b1, 3'd0, 32'h2000_0000); cfg_wr(1'b1, 3'd1, 32'h2FFF_FFFF);
    cfg_wr(1'b1, 3'd2, 32'h0000_2000); cfg_wr(1'b1, 3'd3, 32'h0000_2FFF);
    cfg_wr(1'b1, 3'd4, 32'h0000_0005); cfg_wr(1'b1, 3'd5, 32'h0000_0009);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][56:55], VEC[i][54:53], VEC[i][52:21], VEC[i][20:5], r);
      check($sformatf("vector %0d (R2-R8 table, R12 fields)", i), r,
            {1'b1, VEC[i][4:0]});
    end

    // R9: disabled window (base > limit) on port 1 memory
    cfg_wr(1'b1, 3'd0, 32'h2000_0100); cfg_wr(1'b1, 3'd1, 32'h2000_00FF);
    send(2'd0, 2'd0, 32'h2000_0100, 16'h0, r);
    check("R9 disabled window", r, 6'b1_000_11);
    // R9: single-address window
    cfg_wr(1'b1, 3'd1, 32'h2000_0100);
    send(2'd0, 2'd0, 32'h2000_0100, 16'h0, r);
    check("R9 single address hit", r, 6'b1_100_00);
    send(2'd0, 2'd0, 32'h2000_0101, 16'h0, r);
    check("R9 single address miss", r, 6'b1_000_11);

    // R10: overlapping windows, port 0 wins
    cfg_wr(1'b1, 3'd0, 32'h1000_0000); cfg_wr(1'b1, 3'd1, 32'h1000_FFFF);
    send(2'd0, 2'd0, 32'h1000_0100, 16'h0, r);
    check("R10 overlap priority", r, 6'b1_010_00);

    // R11: stall with a second header waiting
    @(negedge clk);
    out_ready = 1'b0;
    send(2'd0, 2'd0, 32'h1800_0000, 16'h0, r);
    check("R11 first decision", r, 6'b1_010_00);
    check("R11 in_ready low", {5'b0, in_ready}, 6'b0);
    in_valid = 1'b1; in_class = 2'd1; in_port = 2'd0;
    in_addr = 32'h0000_2800; in_rid = 16'h0;
    repeat (3) @(negedge clk);
    check("R11 held during stall", {out_valid, out_egress, out_drop, out_ur},
          6'b1_010_00);
    check("R11 second not taken", {5'b0, in_ready}, 6'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second after release", {out_valid, out_egress, out_drop, out_ur},
          6'b1_100_00);
    @(negedge clk);
    check("R11 drained", {5'b0, out_valid}, 6'b0);

    finish_run();
  end
endmodule